// File: doc/BRIEF.md
# First-M Request Arbiter

This block hands out up to M shared resources, such as memory ports, to requesters taken in fixed priority order, where index 0 has the highest priority. Every position gets a rank: the number of active requesters at or below its index. A log-depth parallel-prefix adder tree computes all the ranks. An active requester whose rank is at most M wins a grant. It is also told which resource it holds: rank minus one, so the winners get distinct numbers from 0 to M-1.

A mode input selects single-grant operation. In that mode, only the lowest-numbered active requester is granted. A prefix-OR tree finds it: that position is the one where the running OR first turns to 1. The request vector and the mode are sampled on each rising clock edge, and grants and resource numbers appear from registers one cycle later. The reset is asserted asynchronously, active low. Its release is synchronised inside the block.

Top module: `first_m_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after the synchronised release, every grant bit and every resource-index field reads 0.
- R2: In multi mode (`single_i`=0), requester i is granted one cycle after sampling exactly when `req_i[i]`=1 and the count of set request bits at positions 0..i is at most M.
- R3: A granted requester's resource index equals its rank minus one, where rank is the count of set request bits at positions 0..i. Requester i's index sits in `slot_o[i*IW +: IW]`, with IW = clog2(M), or 1 when M=1.
- R4: The index field of every requester without a grant reads 0.
- R5: A requester whose request bit was 0 in the sampled cycle never receives a grant.
- R6: No more than M grant bits are set in any cycle.
- R7: In single mode (`single_i`=1), only the lowest-indexed active requester is granted, and its index is 0.
- R8: An all-zero request vector produces no grants in either mode.
- R9: An all-ones request vector in multi mode grants exactly positions 0..M-1, and each of them gets its own position as its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N | One request bit per requester, index 0 highest priority |
| single_i | input | 1 | 1 selects single-grant mode, 0 selects first-M mode |
| grant_o | output | N | Registered grant bit per requester |
| slot_o | output | N*IW | Registered resource index per requester, IW bits each |

## Verification
The bench builds the block with N=13 and M=5. Both values are not powers of two, so the adder tree has ragged upper levels, the index field is three bits wide with codes 5 to 7 unused, and the rank cut-off falls in the middle of the vector. With these values, dense random vectors regularly exceed five requesters and so test the cut-off, while sparse ones leave resources unused. Directed vectors cover the empty and full cases and a lone request at the highest index.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    MODE_MULTI  = 1'b0,
    MODE_SINGLE = 1'b1
  } arb_mode_e;

  function automatic int idx_width(input int m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction

  function automatic int levels(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/prefix_count.sv
module prefix_count #(
  parameter int N  = 32,
  parameter int CW = 6
) (
  input  logic [N-1:0]          bit_i,
  output logic [N-1:0][CW-1:0]  sum_o
);
  localparam int L = arb_pkg::levels(N);

  logic [CW-1:0] lvl [0:L][0:N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign lvl[0][i] = CW'(bit_i[i]);
  end

  // Kogge-Stone: at level k each node adds the partial sum 2**k below it
  for (genvar k = 0; k < L; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= D) begin : g_add
        assign lvl[k+1][i] = lvl[k][i] + lvl[k][i-D];
      end else begin : g_pass
        assign lvl[k+1][i] = lvl[k][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign sum_o[i] = lvl[L][i];
  end
endmodule

// File: rtl/prefix_or.sv
module prefix_or #(
  parameter int N = 32
) (
  input  logic [N-1:0] bit_i,
  output logic [N-1:0] first_o
);
  localparam int L = arb_pkg::levels(N);

  logic [N-1:0] lvl [0:L];
  logic [N-1:0] any_le;

  assign lvl[0] = bit_i;

  for (genvar k = 0; k < L; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= D) begin : g_or
        assign lvl[k+1][i] = lvl[k][i] | lvl[k][i-D];
      end else begin : g_pass
        assign lvl[k+1][i] = lvl[k][i];
      end
    end
  end

  assign any_le = lvl[L];

  // flag the 0->1 step of the running OR
  if (N > 1) begin : g_edge
    assign first_o = any_le ^ {any_le[N-2:0], 1'b0};
  end else begin : g_one
    assign first_o = any_le;
  end
endmodule

// File: rtl/first_m_arbiter.sv
module first_m_arbiter #(
  parameter int N  = 32,
  parameter int M  = 4,
  localparam int IW = arb_pkg::idx_width(M)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic            single_i,
  output logic [N-1:0]    grant_o,
  output logic [N*IW-1:0] slot_o
);
  import arb_pkg::*;

  localparam int CW = $clog2(N + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [N-1:0][CW-1:0] rank;
  logic [N-1:0]         first;
  arb_mode_e            mode;

  assign mode = arb_mode_e'(single_i);

  prefix_count #(.N(N), .CW(CW)) u_count (
    .bit_i (req_i),
    .sum_o (rank)
  );

  prefix_or #(.N(N)) u_first (
    .bit_i   (req_i),
    .first_o (first)
  );

  logic [N-1:0]    grant_d;
  logic [N*IW-1:0] slot_d;

  always_comb begin
    grant_d = '0;
    slot_d  = '0;
    for (int i = 0; i < N; i++) begin
      if (mode == MODE_SINGLE) begin
        grant_d[i] = first[i];
      end else if (req_i[i] && (rank[i] <= CW'(M))) begin
        grant_d[i]          = 1'b1;
        slot_d[i*IW +: IW]  = IW'(rank[i] - CW'(1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      grant_o <= '0;
      slot_o  <= '0;
    end else begin
      grant_o <= grant_d;
      slot_o  <= slot_d;
    end
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) past_ok_q <= 1'b0;
    else            past_ok_q <= 1'b1;
  end

  p_idle_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    past_ok_q |-> ((grant_o & ~$past(req_i)) == '0));

  p_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $countones(grant_o) <= M);

  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (past_ok_q && $past(single_i)) |-> $onehot0(grant_o));

  p_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (past_ok_q && $past(req_i) == '0) |-> (grant_o == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_idle_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      !grant_o[i] |-> (slot_o[i*IW +: IW] == '0));
  end
endmodule

// File: tb/sim_first_m_arbiter.sv
module sim_first_m_arbiter;
  localparam int N  = 13;
  localparam int M  = 5;
  localparam int IW = arb_pkg::idx_width(M);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req;
  logic            single;
  logic [N-1:0]    grant;
  logic [N*IW-1:0] slot;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  first_m_arbiter #(.N(N), .M(M)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .single_i(single),
    .grant_o(grant), .slot_o(slot)
  );

  function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r, input logic s);
    logic [N-1:0] g = '0;
    int cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (r[i]) begin
        cnt++;
        if (s ? (cnt == 1) : (cnt <= M)) g[i] = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [N*IW-1:0] exp_slot(input logic [N-1:0] r, input logic s);
    logic [N*IW-1:0] v = '0;
    int cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (r[i]) begin
        cnt++;
        if (!s && cnt <= M) v[i*IW +: IW] = IW'(cnt - 1);
      end
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] r, input logic s);
    logic [N-1:0]    eg = exp_grant(r, s);
    logic [N*IW-1:0] es = exp_slot(r, s);
    checks++;
    if (grant !== eg) begin
      errors++;
      $display("FAIL %s grant req=%b single=%0d actual=%b expected=%b", tag, r, s, grant, eg);
    end
    checks++;
    if (slot !== es) begin
      errors++;
      $display("FAIL %s slot req=%b single=%0d actual=%h expected=%h", tag, r, s, slot, es);
    end
  endtask

  // drive at negedge, outputs register at posedge, sample at next negedge
  task automatic apply(input string tag, input logic [N-1:0] r, input logic s);
    req = r; single = s;
    @(negedge clk);
    check(tag, r, s);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req = '1; single = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0 || slot !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%h expected=0/0", grant, slot);
    end
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++;
    if (grant !== '0 || slot !== '0) begin
      errors++;
      $display("FAIL R1 post-release actual=%b/%h expected=0/0", grant, slot);
    end
    @(negedge clk);

    apply("R8 empty multi", '0, 1'b0);
    apply("R8 empty single", '0, 1'b1);
    apply("R9 all ones", '1, 1'b0);
    apply("R7 all ones single", '1, 1'b1);
    apply("R2 top only", 13'h1000, 1'b0);
    apply("R7 top only single", 13'h1000, 1'b1);
    apply("R3 sparse", 13'b1010100010101, 1'b0);
    apply("R6 exactly M", 13'b1111100000000, 1'b0);
    apply("R4 one past M", 13'b0000000111111, 1'b0);
    apply("R5 alternating", 13'b0101010101010, 1'b0);
    apply("R7 mid single", 13'b0110000001000, 1'b1);

    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] r = N'($urandom);
      if (n % 4 == 1) r = r & N'($urandom);
      if (n % 4 == 2) r = r | N'($urandom);
      apply((n % 5 == 0) ? "R7 random single" : "R2 R3 random", r, (n % 5 == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule